// File: doc/BRIEF.md
# PWM Timer with Synchronized Buffer Reload

An up-counting, edge-aligned PWM timer. The counter runs from 0 up to an active modulo value and then wraps to 0. The output is high while the counter is below an active compare value. Software never writes the active period or duty directly. Writes land in a pair of shadow buffers, and both buffers are copied into the active registers in the same cycle, only when a synchronization completes.

A synchronization is started either by a one-cycle software strobe or by a rising edge on a hardware trigger line. Each source has its own restart-mode bit, which picks between two behaviours:

- **Restart mode 1:** the trigger copies the buffers at once and forces the counter back to 0.
- **Restart mode 0:** the trigger only arms the copy. The copy then waits for an enabled loading point: the counter at its minimum (0), or the counter at its maximum (the active modulo). Each loading point can be enabled on its own. When both are enabled, the first one reached after the trigger cycle wins.

A busy flag shows that a software-started copy is still waiting.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset the counter reads 0, the PWM output is low and the software busy flag is low. The active modulo is all ones and the active compare is 0, so the first period is 2^CNT_W cycles long.
- R2: A write (wrEn=1, wrSel=0 for modulo, wrSel=1 for compare) changes only a buffer. The counted period and the PWM duty stay unchanged until a synchronization completes.
- R3: With no restart, the counter counts up by one each cycle. In the cycle after it reads the active modulo it reads 0. The PWM output is 1 exactly when the counter is below the active compare.
- R4: A software strobe with swRstMode=0 raises swBusy from the next cycle onward and leaves the counter running. At the next enabled loading point that follows the strobe cycle, both buffers are copied and swBusy falls.
- R5: The minimum loading point is the counter at 0 (loadAtMin), and the maximum loading point is the counter at the active modulo (loadAtMax). With both enabled, the earlier one performs the copy. With neither enabled, an armed copy stays pending for as long as that lasts.
- R6: A software strobe with swRstMode=1 copies both buffers at that edge and makes the counter read 0 in the next cycle. swBusy stays low.
- R7: A 0-to-1 change of hwTrig acts as a trigger, with hwRstMode selecting the same two behaviours as swRstMode. Holding hwTrig high causes no further triggers.
- R8: The modulo and compare buffers are always copied in the same cycle. A new period never runs with a duty value from a different update.
- R9: Restart-mode triggers issued faster than one period keep the counter from ever reaching the modulo, so the output never completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Buffer write strobe |
| wrSel | input | 1 | Buffer select: 0 = modulo, 1 = compare |
| wrData | input | CNT_W | Value written into the selected buffer |
| loadAtMin | input | 1 | Enable the counter-minimum loading point |
| loadAtMax | input | 1 | Enable the counter-maximum loading point |
| swTrig | input | 1 | One-cycle software synchronization strobe |
| hwTrig | input | 1 | Hardware trigger level, rising edge active |
| swRstMode | input | 1 | Software trigger: 1 = immediate copy and restart, 0 = wait for a loading point |
| hwRstMode | input | 1 | Hardware trigger: same encoding as swRstMode |
| swBusy | output | 1 | Software-armed copy still pending |
| cntOut | output | CNT_W | Current counter value |
| pwmOut | output | 1 | Edge-aligned PWM output |

## Verification
The bench builds the timer with CNT_W=4. At that width every pairing of the 16 modulo values and 16 compare values can be loaded through an immediate software synchronization. Each pairing is then checked cycle by cycle over two full periods against arithmetic expectations. The small width also keeps the periods short enough to walk each loading-point case cycle by cycle: minimum only, maximum only, both, neither, and a trigger landing on a loading point itself. The same holds for the held hardware level and for fast repeated restarts.

// File: rtl/pst_pkg.sv
package pst_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic transfer;  // copy both buffers into the active registers
    logic restart;   // force the counter back to zero
  } syncStrobe_t;

  localparam int NUM_SHADOW = 2;
  localparam int IDX_MOD    = 0;
  localparam int IDX_CMP    = 1;

endpackage

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        swTrig,
  input  logic        hwTrig,
  input  logic        swRstMode,
  input  logic        hwRstMode,
  input  logic        loadAtMin,
  input  logic        loadAtMax,
  input  logic        atMin,
  input  logic        atMax,
  output syncStrobe_t strobe,
  output logic        swBusy
);

  logic hwPrev;
  logic swPend;
  logic hwPend;
  logic hwEdge;
  logic immediate;
  logic pointHit;
  logic atPoint;

  assign hwEdge    = hwTrig & ~hwPrev;
  assign immediate = (swTrig & swRstMode) | (hwEdge & hwRstMode);
  assign pointHit  = (loadAtMin & atMin) | (loadAtMax & atMax);
  assign atPoint   = (swPend | hwPend) & pointHit;

  always_comb begin
    strobe          = '0;
    strobe.transfer = immediate | atPoint;
    strobe.restart  = immediate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwPrev <= 1'b0;
      swPend <= 1'b0;
      hwPend <= 1'b0;
    end else begin
      hwPrev <= hwTrig;
      if (immediate) begin
        // a completed copy satisfies every waiting request
        swPend <= 1'b0;
        hwPend <= 1'b0;
      end else begin
        swPend <= (swTrig & ~swRstMode) | (swPend & ~atPoint);
        hwPend <= (hwEdge & ~hwRstMode) | (hwPend & ~atPoint);
      end
    end
  end

  assign swBusy = swPend;

endmodule

// File: rtl/pst_datapath.sv
module pst_datapath
  import pst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  syncStrobe_t      strobe,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] modAct,
  output logic [CNT_W-1:0] cmpAct,
  output logic             atMin,
  output logic             atMax,
  output logic             pwmOut
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO     = {CNT_W{1'b0}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] shadowQ [NUM_SHADOW];
  logic [CNT_W-1:0] activeQ [NUM_SHADOW];

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : gShadow
    localparam logic [CNT_W-1:0] RST_VAL = (i == IDX_MOD) ? ALL_ONES : ZERO;
    localparam logic             SEL_VAL = (i == IDX_CMP);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowQ[i] <= RST_VAL;
        activeQ[i] <= RST_VAL;
      end else begin
        if (wrEn && (wrSel == SEL_VAL)) shadowQ[i] <= wrData;
        if (strobe.transfer)            activeQ[i] <= shadowQ[i];
      end
    end
  end

  assign modAct = activeQ[IDX_MOD];
  assign cmpAct = activeQ[IDX_CMP];
  assign atMin  = (cnt == ZERO);
  assign atMax  = (cnt == modAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= ZERO;
    else if (strobe.restart)  cnt <= ZERO;
    else if (cnt >= modAct)   cnt <= ZERO;
    else                      cnt <= cnt + ONE;
  end

  assign pwmOut = (cnt < cmpAct);

endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer
  import pst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             loadAtMin,
  input  logic             loadAtMax,
  input  logic             swTrig,
  input  logic             hwTrig,
  input  logic             swRstMode,
  input  logic             hwRstMode,
  output logic             swBusy,
  output logic [CNT_W-1:0] cntOut,
  output logic             pwmOut
);

  syncStrobe_t      strobe;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] modAct;
  logic [CNT_W-1:0] cmpAct;
  logic             atMin;
  logic             atMax;

  pst_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .swTrig    (swTrig),
    .hwTrig    (hwTrig),
    .swRstMode (swRstMode),
    .hwRstMode (hwRstMode),
    .loadAtMin (loadAtMin),
    .loadAtMax (loadAtMax),
    .atMin     (atMin),
    .atMax     (atMax),
    .strobe    (strobe),
    .swBusy    (swBusy)
  );

  pst_datapath #(.CNT_W(CNT_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strobe (strobe),
    .cnt    (cnt),
    .modAct (modAct),
    .cmpAct (cmpAct),
    .atMin  (atMin),
    .atMax  (atMax),
    .pwmOut (pwmOut)
  );

  assign cntOut = cnt;

endmodule

// File: rtl/pst_checker.sv
module pst_checker
  import pst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             swTrig,
  input logic             hwTrig,
  input logic             swRstMode,
  input logic             loadAtMin,
  input logic             loadAtMax,
  input logic             swBusy,
  input syncStrobe_t      strobe,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] modAct,
  input logic [CNT_W-1:0] cmpAct,
  input logic             atMin,
  input logic             atMax
);

  // R3: count up below the modulo
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && cnt < modAct) |=> cnt == $past(cnt) + 1'b1);

  // R3: wrap after the modulo
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.restart && cnt >= modAct) |=> cnt == '0);

  // R6: restart clears the counter
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> cnt == '0);

  // R2 and R8: active pair only changes on a transfer
  a_r2_hold_active: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.transfer |=> ($stable(modAct) && $stable(cmpAct)));

  // R5: a non-restart copy only at an enabled loading point
  a_r5_point_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.transfer && !strobe.restart) |-> ((loadAtMin && atMin) || (loadAtMax && atMax)));

  // R4: a waiting strobe arms busy
  a_r4_arm: assert property (@(posedge clk) disable iff (!rstN)
    (swTrig && !swRstMode && !strobe.restart) |=> swBusy);

  // R4: busy drops once the copy is done
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (swBusy && strobe.transfer && !swTrig) |=> !swBusy);

  // R7: a held hardware level does not retrigger
  a_r7_level_held: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hwTrig) && hwTrig && !swTrig) |-> !strobe.restart);

endmodule

bind pwm_sync_timer pst_checker #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .swTrig    (swTrig),
  .hwTrig    (hwTrig),
  .swRstMode (swRstMode),
  .loadAtMin (loadAtMin),
  .loadAtMax (loadAtMax),
  .swBusy    (swBusy),
  .strobe    (strobe),
  .cnt       (cnt),
  .modAct    (modAct),
  .cmpAct    (cmpAct),
  .atMin     (atMin),
  .atMax     (atMax)
);

// File: tb/sim_pwm_sync_timer.sv
`timescale 1ns/1ps
module sim_pwm_sync_timer;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  logic         loadAtMin = 1'b0;
  logic         loadAtMax = 1'b0;
  logic         swTrig = 1'b0;
  logic         hwTrig = 1'b0;
  logic         swRstMode = 1'b0;
  logic         hwRstMode = 1'b0;
  logic         swBusy;
  logic [W-1:0] cntOut;
  logic         pwmOut;

  int nChecks = 0;
  int nErrors = 0;

  always #10 clk = ~clk;

  pwm_sync_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .loadAtMin(loadAtMin), .loadAtMax(loadAtMax), .swTrig(swTrig),
    .hwTrig(hwTrig), .swRstMode(swRstMode), .hwRstMode(hwRstMode),
    .swBusy(swBusy), .cntOut(cntOut), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance to the next falling edge; outputs then reflect the rising edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic wrReg(input bit sel, input int val);
    wrEn = 1'b1; wrSel = sel; wrData = W'(val);
    step();
    wrEn = 1'b0;
  endtask

  task automatic pulseSw();
    swTrig = 1'b1;
    step();
    swTrig = 1'b0;
  endtask

  task automatic waitCnt(input int v);
    for (int i = 0; i < 40; i++) begin
      if (int'(cntOut) == v) return;
      step();
    end
    check(1'b0, "waitCnt", int'(cntOut), v);
  endtask

  // load M and C with an immediate software sync, then counter reads 0
  task automatic loadNow(input int m, input int c);
    wrReg(1'b0, m);
    wrReg(1'b1, c);
    swRstMode = 1'b1;
    pulseSw();
  endtask

  task automatic checkCycle(input string tag, input int k, input int m, input int c);
    int ph;
    ph = k % (m + 1);
    check(int'(cntOut) == ph, {tag, " cnt"}, int'(cntOut), ph);
    check(pwmOut == (ph < c), {tag, " pwm"}, int'(pwmOut), int'(ph < c));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state and full-range default period
    check(cntOut == 0, "R1 cnt after reset", int'(cntOut), 0);
    check(pwmOut == 1'b0, "R1 pwm after reset", int'(pwmOut), 0);
    check(swBusy == 1'b0, "R1 busy after reset", int'(swBusy), 0);
    repeat (15) step();
    check(int'(cntOut) == 15, "R1 default modulo top", int'(cntOut), 15);
    check(pwmOut == 1'b0, "R1 default compare zero", int'(pwmOut), 0);
    step();
    check(cntOut == 0, "R1 default wrap", int'(cntOut), 0);

    // R3 R6 R8: sweep every modulo/compare pairing via immediate sync
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 16; c++) begin
        loadNow(m, c);
        check(swBusy == 1'b0, "R6 busy stays low", int'(swBusy), 0);
        for (int k = 0; k < 2 * (m + 1); k++) begin
          checkCycle("R3 R8 sweep", k, m, c);
          step();
        end
      end
    end

    // R2: buffer writes alone change nothing
    loadNow(5, 2);
    swRstMode = 1'b0;
    wrReg(1'b0, 9);
    wrReg(1'b1, 7);
    for (int i = 0; i < 14; i++) begin
      check(int'(cntOut) <= 5, "R2 period held", int'(cntOut), 5);
      check(pwmOut == (int'(cntOut) < 2), "R2 duty held", int'(pwmOut), int'(int'(cntOut) < 2));
      step();
    end

    // R4: waiting sync at the maximum point
    loadAtMax = 1'b1; loadAtMin = 1'b0;
    waitCnt(2);
    pulseSw();
    check(int'(cntOut) == 3, "R4 counter keeps running", int'(cntOut), 3);
    check(swBusy == 1'b1, "R4 busy armed", int'(swBusy), 1);
    step(); step();
    check(int'(cntOut) == 5 && swBusy, "R4 still old period at max", int'(cntOut), 5);
    step();
    check(cntOut == 0, "R4 wrap at old max", int'(cntOut), 0);
    check(swBusy == 1'b0, "R4 busy cleared", int'(swBusy), 0);
    for (int k = 0; k < 10; k++) begin
      checkCycle("R4 R8 new pair", k, 9, 7);
      step();
    end
    check(cntOut == 0, "R4 new period wraps", int'(cntOut), 0);

    // R5: minimum point only (active M=9 C=7)
    wrReg(1'b0, 4);
    wrReg(1'b1, 1);
    loadAtMax = 1'b0; loadAtMin = 1'b1;
    waitCnt(3);
    pulseSw();
    waitCnt(0);
    check(swBusy == 1'b1, "R5 min: busy at zero", int'(swBusy), 1);
    check(pwmOut == 1'b1, "R5 min: old duty at zero", int'(pwmOut), 1);
    step();
    check(int'(cntOut) == 1 && !swBusy, "R5 min: copy after zero", int'(cntOut), 1);
    check(pwmOut == 1'b0, "R5 min: new duty", int'(pwmOut), 0);
    repeat (3) step();
    check(int'(cntOut) == 4, "R5 min: new top", int'(cntOut), 4);
    step();
    check(cntOut == 0, "R5 min: new wrap", int'(cntOut), 0);

    // R5: both points, maximum comes first (active M=4 C=1)
    wrReg(1'b0, 6);
    wrReg(1'b1, 3);
    loadAtMax = 1'b1;
    waitCnt(1);
    pulseSw();
    step(); step();
    check(int'(cntOut) == 4 && swBusy, "R5 both: pending at max", int'(cntOut), 4);
    step();
    check(cntOut == 0 && !swBusy, "R5 both: copied at max", int'(swBusy), 0);
    for (int k = 0; k < 7; k++) begin
      checkCycle("R5 both: new pair", k, 6, 3);
      step();
    end

    // R5: strobe on the max cycle waits for the following min point
    wrReg(1'b0, 3);
    wrReg(1'b1, 2);
    waitCnt(6);
    pulseSw();
    check(cntOut == 0 && swBusy, "R5 strobe at max: still pending", int'(swBusy), 1);
    step();
    check(int'(cntOut) == 1 && !swBusy, "R5 strobe at max: copied at min", int'(swBusy), 0);
    step(); step();
    check(int'(cntOut) == 3, "R5 strobe at max: new top", int'(cntOut), 3);
    step();
    check(cntOut == 0, "R5 strobe at max: wrap", int'(cntOut), 0);

    // R5: no point enabled keeps the copy pending
    wrReg(1'b0, 5);
    wrReg(1'b1, 5);
    loadAtMin = 1'b0; loadAtMax = 1'b0;
    waitCnt(1);
    pulseSw();
    for (int i = 0; i < 12; i++) begin
      check(swBusy == 1'b1, "R5 none: busy held", int'(swBusy), 1);
      check(int'(cntOut) <= 3, "R5 none: old period", int'(cntOut), 3);
      step();
    end
    loadAtMax = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (!swBusy) break;
      step();
    end
    check(cntOut == 0 && !swBusy, "R5 none: copy once max enabled", int'(cntOut), 0);
    repeat (5) step();
    check(int'(cntOut) == 5 && !pwmOut, "R5 none: new pair", int'(cntOut), 5);

    // R6: immediate restart mid-period (active M=5 C=5)
    wrReg(1'b0, 7);
    wrReg(1'b1, 3);
    swRstMode = 1'b1;
    waitCnt(3);
    pulseSw();
    check(cntOut == 0 && !swBusy, "R6 restart mid-period", int'(cntOut), 0);
    for (int k = 0; k < 8; k++) begin
      checkCycle("R6 new pair", k, 7, 3);
      step();
    end

    // R7: hardware edge with restart, then held level
    wrReg(1'b0, 10);
    wrReg(1'b1, 4);
    hwRstMode = 1'b1;
    waitCnt(5);
    hwTrig = 1'b1;
    step();
    for (int k = 0; k < 22; k++) begin
      checkCycle("R7 held level", k, 10, 4);
      step();
    end

    // R7: hardware edge waiting for the max point
    hwTrig = 1'b0;
    hwRstMode = 1'b0;
    loadAtMin = 1'b0; loadAtMax = 1'b1;
    wrReg(1'b0, 2);
    wrReg(1'b1, 1);
    waitCnt(4);
    hwTrig = 1'b1;
    step();
    check(int'(cntOut) == 5, "R7 wait: no restart", int'(cntOut), 5);
    repeat (5) step();
    check(int'(cntOut) == 10, "R7 wait: old top", int'(cntOut), 10);
    step();
    check(cntOut == 0, "R7 wait: wrap", int'(cntOut), 0);
    step(); step();
    check(int'(cntOut) == 2 && !pwmOut, "R7 wait: new pair", int'(cntOut), 2);
    step();
    check(cntOut == 0, "R7 wait: new wrap", int'(cntOut), 0);
    hwTrig = 1'b0;

    // R9: fast restarts never finish a period
    wrReg(1'b0, 9);
    wrReg(1'b1, 8);
    swRstMode = 1'b1;
    pulseSw();
    for (int i = 0; i < 10; i++) begin
      for (int k = 0; k < 3; k++) begin
        check(int'(cntOut) == k, "R9 restart count", int'(cntOut), k);
        check(pwmOut == 1'b1, "R9 output stuck high", int'(pwmOut), 1);
        if (k < 2) step();
      end
      pulseSw();
    end

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule